// File: doc/BRIEF.md
# Gate Command and Desaturation Fault Controller

This block is the clocked digital core of one isolated power-switch gate channel. Three command inputs arrive asynchronously: a non-inverting command, an inverting command and an active-low enable that also serves as the fault-clear input. Each is brought into the clock domain by a two-flop synchronizer and then passed through a glitch filter that accepts a new level only after it has been stable for a set number of cycles. The gate is commanded on only for the single combination of non-inverting high, inverting low and enable high, and only while no error is present.

Desaturation protection acts only while the gate is on. After each accepted turn-on a blanking count must expire before the digitized desaturation comparator flag is looked at. The flag must then persist for a filter count, after which the gate is forced off and a fault latch sets an active-low fault flag. While the fault is latched, no command turns the gate on. The latch clears only on the rising edge of the filtered enable, and only when that enable had been low for at least a qualification count. A channel-error input from the supervisory logic forces the gate off without latching a fault. A Miller-clamp enable is released at turn-on and asserted after turn-off once the synchronized gate-below-clamp-level flag has been seen.

Top module: `gateFaultCtrl`

## Requirements
- R1: After power-on reset (`rstN` low) the gate command `gateOn` is 0, the fault flag `faultN` is 1 (no fault) and `clampEn` is 1.
- R2: `gateOn` is 1 only when the filtered inputs read `cmdPos`=1, `cmdNeg`=0 and `enRstN`=1; a change of a raw input reaches `gateOn` after 2 synchronizer cycles, FILT_CYC filter cycles and 1 output register cycle.
- R3: A pulse on `cmdPos`, `cmdNeg` or `enRstN` lasting fewer than FILT_CYC clock cycles does not change `gateOn`; one lasting FILT_CYC cycles is accepted.
- R4: During the first BLANK_CYC cycles after each accepted off-to-on transition of `gateOn`, `desatFlag` is ignored; the blanking count restarts at every turn-on.
- R5: Once blanking has expired, `desatFlag` high for DESAT_CYC consecutive synchronized cycles while the gate is on turns `gateOn` off and drives `faultN` to 0 at the same clock edge; a run of DESAT_CYC-1 cycles has no effect.
- R6: While the fault is latched (`faultN`=0) `gateOn` stays 0 whatever the command inputs do, and a turn-on command is ignored.
- R7: The fault clears at the rising edge of the filtered `enRstN` only if it had been low for at least RST_QUAL_CYC cycles; a shorter low period leaves `faultN` at 0.
- R8: `chanErr` high forces `gateOn` to 0 at the next clock edge and holds it off while high, without setting the fault latch.
- R9: `clampEn` is 0 whenever `gateOn` is 1; after a turn-off it becomes 1 one cycle after the synchronized `gateLowFlag` is seen high, and stays 1 until the next turn-on.
- R10: A desaturation trip that falls in the same cycle as a command turn-off still latches the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| cmdPos | input | 1 | Non-inverting gate command, asynchronous |
| cmdNeg | input | 1 | Inverting gate command, asynchronous |
| enRstN | input | 1 | Active-low shutdown and fault-clear input, asynchronous |
| desatFlag | input | 1 | Digitized desaturation comparator output, asynchronous |
| gateLowFlag | input | 1 | Gate voltage below clamp level, asynchronous |
| chanErr | input | 1 | Supervisory error (undervoltage or transfer error), synchronous |
| gateOn | output | 1 | Gate-on command to the output stage |
| clampEn | output | 1 | Miller-clamp enable |
| faultN | output | 1 | Active-low latched desaturation fault |

## Verification
The desaturation trip and a command turn-off can fall on the same clock edge; the trip must win and latch the fault even though the gate would have gone off anyway. A directed case holds `desatFlag` high through turn-on and drops `cmdPos` so that its filtered fall reaches the gate in exactly the cycle the filter count completes, and the bench expects `faultN` at 0 afterwards. Random stimulus with hold times from one to fifty cycles also lands channel errors, enable pulses and desaturation runs on top of each other, and every cycle is judged against a cycle model built from the requirements.

// File: rtl/gfcPkg.sv
package gfcPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic onState;   // gate currently commanded on: runs blanking count
    logic senseArm;  // blanking expired while on: desat count may run
  } ctrlStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic cmdReq;    // filtered command asks for gate on
    logic blankDone; // blanking count reached its limit
    logic desatTrip; // desat flag persisted through the filter count
    logic clearOk;   // qualified rising edge of the enable
    logic gateLow;   // synchronized gate-below-clamp flag
  } dpStatus_t;

endpackage

// File: rtl/gfcDatapath.sv
module gfcDatapath
  import gfcPkg::*;
#(
  parameter int FILT_CYC     = 2,
  parameter int BLANK_CYC    = 20,
  parameter int DESAT_CYC    = 12,
  parameter int RST_QUAL_CYC = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdPos,
  input  logic        cmdNeg,
  input  logic        enRstN,
  input  logic        desatFlag,
  input  logic        gateLowFlag,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int NUM_SYNC = 5;
  localparam int NUM_FILT = 3;
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int DW = $clog2(DESAT_CYC + 1);
  localparam int RW = $clog2(RST_QUAL_CYC + 1);
  // Reset levels: every input at its gate-off level
  localparam logic [NUM_SYNC-1:0] SYNC_INIT = 5'b00010;

  logic [NUM_SYNC-1:0] rawVec;
  logic [NUM_SYNC-1:0] syncVec;
  logic [NUM_FILT-1:0] filtVec;

  assign rawVec = {gateLowFlag, desatFlag, enRstN, cmdNeg, cmdPos};

  // Two-flop synchronizers
  for (genvar i = 0; i < NUM_SYNC; i++) begin : g_sync
    logic [1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= {2{SYNC_INIT[i]}};
      else       pipe <= {pipe[0], rawVec[i]};
    end
    assign syncVec[i] = pipe[1];
  end

  // Minimum-pulse filters on the three command inputs
  for (genvar i = 0; i < NUM_FILT; i++) begin : g_filt
    logic          level;
    logic [FW-1:0] runCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        level  <= SYNC_INIT[i];
        runCnt <= '0;
      end else if (syncVec[i] == level) begin
        runCnt <= '0;
      end else if (runCnt == FW'(FILT_CYC - 1)) begin
        level  <= syncVec[i];
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
    assign filtVec[i] = level;
  end

  logic posF, negF, enF, desS;
  assign posF = filtVec[0];
  assign negF = filtVec[1];
  assign enF  = filtVec[2];
  assign desS = syncVec[3];

  // Leading-edge blanking counter, held at zero while off
  logic [BW-1:0] blankCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         blankCnt <= '0;
    else if (!strobe.onState)          blankCnt <= '0;
    else if (blankCnt != BW'(BLANK_CYC)) blankCnt <= blankCnt + 1'b1;
  end

  // Desaturation persistence counter
  logic [DW-1:0] desCnt;
  logic          desRun;
  assign desRun = strobe.senseArm & desS;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          desCnt <= '0;
    else if (!desRun)                   desCnt <= '0;
    else if (desCnt != DW'(DESAT_CYC))  desCnt <= desCnt + 1'b1;
  end

  // Enable low-time counter, saturating, and edge detector
  logic [RW-1:0] lowCnt;
  logic          enDly;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      enDly  <= 1'b0;
    end else begin
      enDly <= enF;
      if (enF)                                lowCnt <= '0;
      else if (lowCnt != RW'(RST_QUAL_CYC))   lowCnt <= lowCnt + 1'b1;
    end
  end

  assign status.cmdReq    = posF & ~negF & enF;
  assign status.blankDone = (blankCnt == BW'(BLANK_CYC));
  assign status.desatTrip = desRun & (desCnt == DW'(DESAT_CYC - 1));
  assign status.clearOk   = enF & ~enDly & (lowCnt == RW'(RST_QUAL_CYC));
  assign status.gateLow   = syncVec[4];

endmodule

// File: rtl/gfcControl.sv
module gfcControl
  import gfcPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chanErr,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        gateOn,
  output logic        clampEn,
  output logic        faultN
);

  logic gateQ, faultQ, clampQ;
  logic gateNext, clampNext, faultNext;

  assign strobe.onState  = gateQ;
  assign strobe.senseArm = gateQ & status.blankDone;

  // Any error or a trip in this cycle blocks the gate
  assign gateNext  = status.cmdReq & ~chanErr & ~faultQ & ~status.desatTrip;
  // Trip has priority over clear
  assign faultNext = status.desatTrip ? 1'b1 :
                     status.clearOk   ? 1'b0 : faultQ;
  assign clampNext = ~gateNext & (clampQ | status.gateLow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateQ  <= 1'b0;
      faultQ <= 1'b0;
      clampQ <= 1'b1;
    end else begin
      gateQ  <= gateNext;
      faultQ <= faultNext;
      clampQ <= clampNext;
    end
  end

  assign gateOn  = gateQ;
  assign clampEn = clampQ;
  assign faultN  = ~faultQ;

endmodule

// File: rtl/gateFaultCtrl.sv
module gateFaultCtrl
  import gfcPkg::*;
#(
  parameter int FILT_CYC     = 2,
  parameter int BLANK_CYC    = 20,
  parameter int DESAT_CYC    = 12,
  parameter int RST_QUAL_CYC = 40
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdPos,
  input  logic cmdNeg,
  input  logic enRstN,
  input  logic desatFlag,
  input  logic gateLowFlag,
  input  logic chanErr,
  output logic gateOn,
  output logic clampEn,
  output logic faultN
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  gfcDatapath #(
    .FILT_CYC    (FILT_CYC),
    .BLANK_CYC   (BLANK_CYC),
    .DESAT_CYC   (DESAT_CYC),
    .RST_QUAL_CYC(RST_QUAL_CYC)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmdPos     (cmdPos),
    .cmdNeg     (cmdNeg),
    .enRstN     (enRstN),
    .desatFlag  (desatFlag),
    .gateLowFlag(gateLowFlag),
    .strobe     (strobe),
    .status     (status)
  );

  gfcControl i_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .chanErr(chanErr),
    .status (status),
    .strobe (strobe),
    .gateOn (gateOn),
    .clampEn(clampEn),
    .faultN (faultN)
  );

endmodule

// File: rtl/gateFaultCtrlChk.sv
module gateFaultCtrlChk (
  input logic clk,
  input logic rstN,
  input logic chanErr,
  input logic gateOn,
  input logic clampEn,
  input logic faultN
);

  // R8
  err_forces_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanErr |=> !gateOn);

  // R6
  fault_holds_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !faultN |=> !gateOn);

  // R5
  trip_with_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultN) |-> $fell(gateOn));

  // R7
  clear_while_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultN) |-> !gateOn);

  // R9
  clamp_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateOn |-> !clampEn);

endmodule

bind gateFaultCtrl gateFaultCtrlChk i_chk (.*);

// File: tb/test_gateFaultCtrl.sv
`timescale 1ns/1ps
module test_gateFaultCtrl;

  localparam int FILT  = 2;
  localparam int BLANK = 20;
  localparam int DESAT = 12;
  localparam int RSTQ  = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdPos = 1'b0, cmdNeg = 1'b1, enRstN = 1'b1;
  logic desatFlag = 1'b0, gateLowFlag = 1'b0, chanErr = 1'b0;
  logic gateOn, clampEn, faultN;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gateFaultCtrl #(
    .FILT_CYC(FILT), .BLANK_CYC(BLANK), .DESAT_CYC(DESAT), .RST_QUAL_CYC(RSTQ)
  ) i_gateFaultCtrl (
    .clk(clk), .rstN(rstN), .cmdPos(cmdPos), .cmdNeg(cmdNeg), .enRstN(enRstN),
    .desatFlag(desatFlag), .gateLowFlag(gateLowFlag), .chanErr(chanErr),
    .gateOn(gateOn), .clampEn(clampEn), .faultN(faultN)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle model derived from the requirements
  logic [4:0] mS1, mS2;
  logic [2:0] mF;
  int mFc[3];
  int mBlank, mDes, mLow;
  logic mEnD, mFault, mGate, mClamp;

  function automatic logic mReq();
    return mF[0] & ~mF[1] & mF[2];
  endfunction

  always @(posedge clk or negedge rstN) begin
    logic armed, trip, clr, gNext;
    if (!rstN) begin
      mS1 <= 5'b00010; mS2 <= 5'b00010; mF <= 3'b010;
      for (int i = 0; i < 3; i++) mFc[i] <= 0;
      mBlank <= 0; mDes <= 0; mLow <= 0;
      mEnD <= 1'b0; mFault <= 1'b0; mGate <= 1'b0; mClamp <= 1'b1;
    end else begin
      armed = mGate && (mBlank == BLANK);
      trip  = armed && mS2[3] && (mDes == DESAT - 1);
      clr   = mF[2] && !mEnD && (mLow >= RSTQ);
      gNext = mReq() && !chanErr && !mFault && !trip;
      mS1 <= {gateLowFlag, desatFlag, enRstN, cmdNeg, cmdPos};
      mS2 <= mS1;
      for (int i = 0; i < 3; i++) begin
        if (mS2[i] == mF[i]) mFc[i] <= 0;
        else if (mFc[i] + 1 >= FILT) begin mF[i] <= mS2[i]; mFc[i] <= 0; end
        else mFc[i] <= mFc[i] + 1;
      end
      mBlank <= !mGate ? 0 : (mBlank < BLANK ? mBlank + 1 : mBlank);
      mDes   <= (armed && mS2[3]) ? mDes + 1 : 0;
      mLow   <= mF[2] ? 0 : (mLow < RSTQ ? mLow + 1 : mLow);
      mEnD   <= mF[2];
      if (trip) mFault <= 1'b1;
      else if (clr) mFault <= 1'b0;
      mGate  <= gNext;
      mClamp <= !gNext && (mClamp || mS2[4]);
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(gateOn,  mGate,   "R2 model gateOn");
      chk(faultN,  !mFault, "R5 model faultN");
      chk(clampEn, mClamp,  "R9 model clampEn");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  int holdLeft;

  initial begin
    void'($urandom(32'h1c3a5));
    cyc(3);
    // R1 reset state
    chk(gateOn, 1'b0, "R1 gateOn in reset");
    chk(faultN, 1'b1, "R1 faultN in reset");
    chk(clampEn, 1'b1, "R1 clampEn in reset");
    rstN = 1'b1;
    cyc(1);
    chk(gateOn, 1'b0, "R1 gateOn after reset");
    chk(clampEn, 1'b1, "R1 clampEn after reset");

    // R2 turn on and off by the inverting input
    cmdPos = 1'b1; cmdNeg = 1'b0; cyc(10);
    chk(gateOn, 1'b1, "R2 on combination");
    chk(clampEn, 1'b0, "R9 clamp released when on");
    cmdNeg = 1'b1; cyc(10);
    chk(gateOn, 1'b0, "R2 inverting input high");
    chk(clampEn, 1'b0, "R9 clamp waits for low flag");
    gateLowFlag = 1'b1; cyc(5);
    chk(clampEn, 1'b1, "R9 clamp after low flag");
    gateLowFlag = 1'b0; cyc(3);
    chk(clampEn, 1'b1, "R9 clamp holds");
    cmdNeg = 1'b0; cyc(10);
    chk(gateOn, 1'b1, "R2 back on");

    // R3 glitch shorter than the filter
    cmdPos = 1'b0; cyc(FILT - 1); cmdPos = 1'b1;
    for (int k = 0; k < 8; k++) begin
      cyc(1);
      chk(gateOn, 1'b1, "R3 short pulse rejected");
    end
    enRstN = 1'b0; cyc(FILT - 1); enRstN = 1'b1; cyc(8);
    chk(gateOn, 1'b1, "R3 short enable pulse rejected");

    // R5 desat run one cycle short, then exact
    desatFlag = 1'b1; cyc(DESAT - 1); desatFlag = 1'b0; cyc(10);
    chk(faultN, 1'b1, "R5 short desat ignored");
    chk(gateOn, 1'b1, "R5 gate stays on");
    desatFlag = 1'b1; cyc(DESAT); desatFlag = 1'b0; cyc(10);
    chk(faultN, 1'b0, "R5 desat trips");
    chk(gateOn, 1'b0, "R5 gate forced off");

    // R6 new turn-on ignored while faulted
    cmdPos = 1'b0; cyc(10); cmdPos = 1'b1; cyc(15);
    chk(gateOn, 1'b0, "R6 turn-on ignored");

    // R7 short reset low keeps fault, long one clears
    enRstN = 1'b0; cyc(RSTQ - 10); enRstN = 1'b1; cyc(10);
    chk(faultN, 1'b0, "R7 short reset keeps fault");
    enRstN = 1'b0; cyc(RSTQ + 5); enRstN = 1'b1; cyc(10);
    chk(faultN, 1'b1, "R7 long reset clears fault");
    chk(gateOn, 1'b1, "R7 gate on after clear");

    // R4 blanking: desat held across turn-on
    cmdPos = 1'b0; cyc(10);
    desatFlag = 1'b1; cmdPos = 1'b1; cyc(5 + BLANK + 2);
    chk(gateOn, 1'b1, "R4 on during blanking");
    chk(faultN, 1'b1, "R4 no fault during blanking");
    cyc(20);
    chk(faultN, 1'b0, "R4 trip after blanking");
    desatFlag = 1'b0;
    enRstN = 1'b0; cyc(RSTQ + 5); enRstN = 1'b1; cyc(10);
    chk(faultN, 1'b1, "R7 cleared again");

    // R10 trip coinciding with command turn-off
    cmdPos = 1'b0; cyc(10);
    desatFlag = 1'b1; cmdPos = 1'b1;
    cyc(32); cmdPos = 1'b0; cyc(20);
    chk(gateOn, 1'b0, "R10 gate off");
    chk(faultN, 1'b0, "R10 fault latched on collision");
    desatFlag = 1'b0;
    enRstN = 1'b0; cyc(RSTQ + 5); enRstN = 1'b1;
    cmdPos = 1'b1; cyc(12);
    chk(gateOn, 1'b1, "R2 on after recovery");

    // R8 channel error
    chanErr = 1'b1; cyc(2);
    chk(gateOn, 1'b0, "R8 error forces off");
    chk(faultN, 1'b1, "R8 no fault latched");
    chanErr = 1'b0; cyc(2);
    chk(gateOn, 1'b1, "R8 back on after error");

    // Random phase, judged by the cycle model
    holdLeft = 0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (holdLeft == 0) begin
        cmdPos      = ($urandom % 4) != 0;
        cmdNeg      = ($urandom % 5) == 0;
        enRstN      = ($urandom % 8) != 0;
        desatFlag   = ($urandom % 6) == 0;
        gateLowFlag = ($urandom % 2) == 0;
        chanErr     = ($urandom % 20) == 0;
        holdLeft    = 1 + ($urandom % 50);
      end else begin
        holdLeft--;
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule